// File: doc/BRIEF.md
# System Management Memory Access Guard

This block sits on the request path in front of system memory and decides, one request at a time, whether an access may reach the memory reserved for system-management mode. Three regions are guarded, each with its own enable: a legacy window under the 1 MB line, a fixed segment placed just past 1 MB, and a segment whose size is programmable and whose upper edge is the top of installed memory. Each request carries an address, a requester code and a flag saying whether the processor is currently in management mode.

The decision comes out one clock after the request as a two-bit code. The access may be plain memory, it may be management memory, it may be sent on to the legacy video path, or it may be refused with a master abort. Peripheral bus masters never get into a guarded region. A configuration "open" bit lets the processor reach the regions outside management mode while firmware sets them up. A sticky lock bit, which only reset clears, cancels that override.

Top module: `smm_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dec_valid` is 0 and `dec_code` is 00. The lock is clear after reset.
- R2: `dec_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. `dec_code` carries the decision for that request in the same cycle.
- R3: When `cfg_region_en[0]` is set, addresses 0xA0000 to 0xBFFFF form the legacy region. A processor request (`req_src` 00) in management mode gets code 01. Without management mode and without an active override it gets code 10 (redirect to the legacy video path).
- R4: When `cfg_region_en[1]` is set, addresses 0x100000 to 0x11FFFF form the high segment. A processor request in management mode gets 01. Without management mode and without an active override it gets 11 (abort).
- R5: When `cfg_region_en[2]` is set, the top segment spans `cfg_tom` minus size up to `cfg_tom`, with the lower edge included and the upper edge excluded. `cfg_top_size` selects the size: 00 is 128 KB, 01 is 512 KB, 10 is 1 MB, and 11 disables the segment. Processor requests get 01 in management mode and 11 otherwise.
- R6: A request from any non-processor source gets 11 whenever it hits an enabled region, regardless of `req_smm` and `cfg_open`. The sources are `req_src` 01 (I/O hub), 10 (graphics port) and 11 (other peripheral).
- R7: An address outside every enabled region gets code 00 (normal memory).
- R8: While the lock is clear and `cfg_open` is 1, a processor request outside management mode that hits an enabled region gets 01.
- R9: A one-cycle pulse on `cfg_lock_set` sets the lock. Once the lock is set, `cfg_open` has no effect, and only `rst` clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_src | input | 2 | Requester: 00 processor, 01 I/O hub, 10 graphics, 11 other |
| req_smm | input | 1 | Processor is in management mode |
| cfg_region_en | input | 3 | Enables: [0] legacy, [1] high, [2] top segment |
| cfg_top_size | input | 2 | Top segment size select |
| cfg_tom | input | ADDR_W | Top of installed memory |
| cfg_open | input | 1 | Override for non-management processor access |
| cfg_lock_set | input | 1 | Sets the sticky lock |
| dec_valid | output | 1 | Decision present |
| dec_code | output | 2 | 00 normal, 01 management, 10 redirect, 11 abort |

## Verification
The only internal state that outlives a request is the lock. If the lock is wrongly set or wrongly cleared, the first non-management processor request that hits a region while `cfg_open` is high shows it. One cycle after that request, the code reads 01 where 10 or 11 was expected, or the reverse. A mistake in a region compare or in the size decode has no stored effect. It shows up only for addresses at the exact region edges, and the edge vectors catch it one cycle after the request.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [1:0] {
    DEC_NORMAL   = 2'b00,
    DEC_SMRAM    = 2'b01,
    DEC_REDIRECT = 2'b10,
    DEC_ABORT    = 2'b11
  } dec_e;

  localparam logic [1:0] SRC_CPU = 2'b00;

  localparam int unsigned NUM_FIXED = 2;
  localparam int unsigned REGION_EN_W = NUM_FIXED + 1;
endpackage

// File: rtl/smm_window.sv
module smm_window #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = 'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LIMIT = BASE + SIZE;

  always_comb begin
    hit = en && (addr >= BASE) && (addr < LIMIT);
  end
endmodule

// File: rtl/smm_topseg.sv
module smm_topseg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic [1:0]        size_sel,
  input  logic [ADDR_W-1:0] tom,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] SZ_128K = ADDR_W'(32'h0002_0000);
  localparam logic [ADDR_W-1:0] SZ_512K = ADDR_W'(32'h0008_0000);
  localparam logic [ADDR_W-1:0] SZ_1M   = ADDR_W'(32'h0010_0000);

  logic [ADDR_W-1:0] seg_size;
  logic [ADDR_W-1:0] seg_base;
  logic              size_ok;

  always_comb begin
    size_ok  = 1'b1;
    seg_size = SZ_128K;
    case (size_sel)
      2'b00:   seg_size = SZ_128K;
      2'b01:   seg_size = SZ_512K;
      2'b10:   seg_size = SZ_1M;
      default: size_ok  = 1'b0;
    endcase
    seg_base = tom - seg_size;
    hit = en && size_ok && (tom >= seg_size) &&
          (addr >= seg_base) && (addr < tom);
  end
endmodule

// File: rtl/smm_lock.sv
module smm_lock (
  input  logic clk,
  input  logic rst,
  input  logic set,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst)      locked <= 1'b0;
    else if (set) locked <= 1'b1;
  end
endmodule

// File: rtl/smm_guard.sv
module smm_guard
  import smm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LEGACY_BASE = ADDR_W'(32'h000A_0000),
  parameter logic [ADDR_W-1:0] LEGACY_SIZE = ADDR_W'(32'h0002_0000),
  parameter logic [ADDR_W-1:0] HIGH_BASE   = ADDR_W'(32'h0010_0000),
  parameter logic [ADDR_W-1:0] HIGH_SIZE   = ADDR_W'(32'h0002_0000)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_src,
  input  logic                   req_smm,
  input  logic [REGION_EN_W-1:0] cfg_region_en,
  input  logic [1:0]             cfg_top_size,
  input  logic [ADDR_W-1:0]      cfg_tom,
  input  logic                   cfg_open,
  input  logic                   cfg_lock_set,
  output logic                   dec_valid,
  output logic [1:0]             dec_code
);
  localparam logic [NUM_FIXED-1:0][ADDR_W-1:0] FIX_BASE = {HIGH_BASE, LEGACY_BASE};
  localparam logic [NUM_FIXED-1:0][ADDR_W-1:0] FIX_SIZE = {HIGH_SIZE, LEGACY_SIZE};

  logic [NUM_FIXED-1:0] fixed_hit;
  logic                 top_hit;
  logic                 legacy_hit;
  logic                 hit_any;
  logic                 lock_q;
  logic                 may_enter;
  dec_e                 next_code;

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
    smm_window #(
      .ADDR_W(ADDR_W),
      .BASE  (FIX_BASE[g]),
      .SIZE  (FIX_SIZE[g])
    ) u_win (
      .addr(req_addr),
      .en  (cfg_region_en[g]),
      .hit (fixed_hit[g])
    );
  end

  smm_topseg #(.ADDR_W(ADDR_W)) u_top (
    .addr    (req_addr),
    .en      (cfg_region_en[NUM_FIXED]),
    .size_sel(cfg_top_size),
    .tom     (cfg_tom),
    .hit     (top_hit)
  );

  smm_lock u_lock (
    .clk   (clk),
    .rst   (rst),
    .set   (cfg_lock_set),
    .locked(lock_q)
  );

  always_comb begin
    legacy_hit = fixed_hit[0];
    hit_any    = (|fixed_hit) | top_hit;
    may_enter  = req_smm | (cfg_open & ~lock_q);
    if (!hit_any)               next_code = DEC_NORMAL;
    else if (req_src != SRC_CPU) next_code = DEC_ABORT;
    else if (may_enter)         next_code = DEC_SMRAM;
    else if (legacy_hit)        next_code = DEC_REDIRECT;
    else                        next_code = DEC_ABORT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_code  <= DEC_NORMAL;
    end else begin
      dec_valid <= req_valid;
      if (req_valid) dec_code <= next_code;
    end
  end
endmodule

// File: rtl/smm_guard_chk.sv
module smm_guard_chk
  import smm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] req_src,
  input logic       req_smm,
  input logic       hit_any,
  input logic       legacy_hit,
  input logic       lock_q,
  input logic       dec_valid,
  input logic [1:0] dec_code
);
  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);
  // R2
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);
  // R6
  a_r6_foreign_kept_out: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_src != SRC_CPU) |=> dec_code != DEC_SMRAM);
  // R7
  a_r7_miss_is_normal: assert property (@(posedge clk) disable iff (rst)
    req_valid && !hit_any |=> dec_code == DEC_NORMAL);
  // R3
  a_r3_redirect_legacy_only: assert property (@(posedge clk) disable iff (rst)
    req_valid && !legacy_hit |=> dec_code != DEC_REDIRECT);
  // R9
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  // R9
  a_r9_locked_needs_smm: assert property (@(posedge clk) disable iff (rst)
    req_valid && lock_q && !req_smm |=> dec_code != DEC_SMRAM);
endmodule

bind smm_guard smm_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_src   (req_src),
  .req_smm   (req_smm),
  .hit_any   (hit_any),
  .legacy_hit(legacy_hit),
  .lock_q    (lock_q),
  .dec_valid (dec_valid),
  .dec_code  (dec_code)
);

// File: tb/test_smm_guard.sv
module test_smm_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [AW-1:0] TOM = 32'h0800_0000;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  src;
    logic        smm;
    logic [2:0]  en;
    logic [1:0]  sz;
    logic        open;
    logic [1:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{32'h000A_0000, 2'd0, 1'b1, 3'b111, 2'd0, 1'b0, 2'b01, 4'd3}, // R3
    '{32'h000B_FFFF, 2'd0, 1'b0, 3'b111, 2'd0, 1'b0, 2'b10, 4'd3}, // R3
    '{32'h000C_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b0, 2'b00, 4'd7}, // R7
    '{32'h0009_FFFF, 2'd0, 1'b1, 3'b111, 2'd0, 1'b0, 2'b00, 4'd7}, // R7
    '{32'h0010_0000, 2'd0, 1'b1, 3'b111, 2'd0, 1'b0, 2'b01, 4'd4}, // R4
    '{32'h0011_FFFF, 2'd0, 1'b0, 3'b111, 2'd0, 1'b0, 2'b11, 4'd4}, // R4
    '{32'h0012_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b0, 2'b00, 4'd7}, // R7
    '{32'h07FE_0000, 2'd0, 1'b1, 3'b111, 2'd0, 1'b0, 2'b01, 4'd5}, // R5
    '{32'h07FD_FFFF, 2'd0, 1'b1, 3'b111, 2'd0, 1'b0, 2'b00, 4'd5}, // R5
    '{32'h07F8_0000, 2'd0, 1'b0, 3'b111, 2'd1, 1'b0, 2'b11, 4'd5}, // R5
    '{32'h07F7_FFFF, 2'd0, 1'b1, 3'b111, 2'd1, 1'b0, 2'b00, 4'd5}, // R5
    '{32'h07F0_0000, 2'd0, 1'b1, 3'b111, 2'd2, 1'b0, 2'b01, 4'd5}, // R5
    '{32'h0800_0000, 2'd0, 1'b1, 3'b111, 2'd2, 1'b0, 2'b00, 4'd5}, // R5
    '{32'h07FF_FFFF, 2'd0, 1'b1, 3'b111, 2'd3, 1'b0, 2'b00, 4'd5}, // R5
    '{32'h000A_0000, 2'd1, 1'b1, 3'b111, 2'd0, 1'b0, 2'b11, 4'd6}, // R6
    '{32'h07FF_FFFF, 2'd2, 1'b1, 3'b111, 2'd0, 1'b0, 2'b11, 4'd6}, // R6
    '{32'h0010_0000, 2'd3, 1'b1, 3'b111, 2'd0, 1'b1, 2'b11, 4'd6}, // R6
    '{32'h000A_0000, 2'd0, 1'b1, 3'b000, 2'd0, 1'b0, 2'b00, 4'd7}, // R7
    '{32'h0010_0000, 2'd0, 1'b1, 3'b101, 2'd0, 1'b0, 2'b00, 4'd7}, // R7
    '{32'h07FF_FFFF, 2'd0, 1'b0, 3'b111, 2'd0, 1'b1, 2'b01, 4'd8}, // R8
    '{32'h000A_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b1, 2'b01, 4'd8}, // R8
    '{32'h0020_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b1, 2'b00, 4'd7}  // R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_src = 2'd0;
  logic          req_smm = 1'b0;
  logic [2:0]    cfg_region_en = 3'b111;
  logic [1:0]    cfg_top_size = 2'd0;
  logic [AW-1:0] cfg_tom = TOM;
  logic          cfg_open = 1'b0;
  logic          cfg_lock_set = 1'b0;
  logic          dec_valid;
  logic [1:0]    dec_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_guard #(.ADDR_W(AW)) i_smm_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_src(req_src), .req_smm(req_smm), .cfg_region_en(cfg_region_en),
    .cfg_top_size(cfg_top_size), .cfg_tom(cfg_tom), .cfg_open(cfg_open),
    .cfg_lock_set(cfg_lock_set), .dec_valid(dec_valid), .dec_code(dec_code)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [1:0] s, input logic m,
                       input logic [2:0] e, input logic [1:0] z, input logic o);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_src = s; req_smm = m;
    cfg_region_en = e; cfg_top_size = z; cfg_open = o;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    // R1: outputs held during reset even with a request present
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {1'b0, dec_valid}, 2'b00);
    check("R1 code in reset", dec_code, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {1'b0, dec_valid}, 2'b00);
    check("R2 idle no valid", {1'b0, dec_valid}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].addr, VEC[i].src, VEC[i].smm, VEC[i].en, VEC[i].sz, VEC[i].open);
      check($sformatf("R2 valid vec %0d", i), {1'b0, dec_valid}, 2'b01);
      check($sformatf("R%0d vec %0d", VEC[i].req, i), dec_code, VEC[i].exp);
    end
    @(negedge clk);
    check("R2 valid drops", {1'b0, dec_valid}, 2'b00);

    // R9: set lock, open no longer grants access
    cfg_lock_set = 1'b1;
    @(negedge clk);
    cfg_lock_set = 1'b0;
    issue(32'h000A_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b1);
    check("R9 locked legacy redirect", dec_code, 2'b10);
    issue(32'h0010_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b1);
    check("R9 locked high abort", dec_code, 2'b11);
    issue(32'h07FF_0000, 2'd0, 1'b1, 3'b111, 2'd0, 1'b1);
    check("R9 locked smm allowed", dec_code, 2'b01);
    repeat (5) @(negedge clk);
    issue(32'h0010_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b1);
    check("R9 lock persists", dec_code, 2'b11);

    // R1/R9: reset clears lock
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 code after mid reset", dec_code, 2'b00);
    rst = 1'b0;
    issue(32'h0010_0000, 2'd0, 1'b0, 3'b111, 2'd0, 1'b1);
    check("R9 reset unlocks open", dec_code, 2'b01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule